// File: doc/BRIEF.md
# Two-Channel DMA Engine

This block moves data without processor involvement. Each transfer unit is handled in two bus cycles on a single-master request/grant bus that has ready handshaking. The first cycle reads the unit from a source address. The second writes the same value to a destination address. Either address may point at memory or at an I/O location. There are two independent channels. Each holds its own source and destination address, a unit count, a unit size, a bus-holding mode and a trigger type. A run is started by a one-cycle software request pulse, or it is paced by the channel's external request line.

One central state machine owns the bus. Its states are:

- `S_IDLE`: arbitration.
- `S_REQ`: waiting for grant.
- `S_RD`: read cycle.
- `S_WR`: write cycle.
- `S_REL`: bus release after a unit in cycle-steal mode.
- `S_DONE`: release after the final unit.
- `S_FAIL`: release after a bus error.

The transitions are:

- `S_IDLE`→`S_REQ` when any channel is requesting.
- `S_REQ`→`S_RD` on grant.
- `S_RD`→`S_WR` on a clean ready.
- `S_RD`/`S_WR`→`S_FAIL` on an error response.
- `S_WR`→`S_RD` for a further unit in burst mode.
- `S_WR`→`S_REL` for a further unit in cycle-steal mode.
- `S_WR`→`S_DONE` after the final unit.
- `S_REL`/`S_DONE`/`S_FAIL`→`S_IDLE` unconditionally.

Between units in cycle-steal mode the engine re-arbitrates, using either fixed priority or round-robin priority.

Each channel also has:

- a request-clear pulse, used in handshake mode;
- a final-unit indicator;
- a sticky error flag;
- an interrupt that can be masked.

Top module: `dma2_engine`

## Requirements
- R1: `cfg_load` is accepted only while the channel is idle. After a load, each unit is a read at the source address followed by a write of the read data to the destination address. `bus_size` carries the unit code: 0 = 8 bit, 1 = 16 bit, 2 = 32 bit.
- R2: After each unit, an address whose increment bit is set advances by the unit size in bytes (1, 2 or 4). An address whose increment bit is clear stays fixed.
- R3: A count of N (1..65535) moves exactly N units. A count of 0 moves 65,536 units.
- R4: When `prio_rr`=0 and both channels request, channel 0 is always served first.
- R5: When `prio_rr`=1 and both channels request, the channel served most recently loses. After reset, channel 1 counts as most recently served.
- R6: In cycle-steal mode (`cfg_burst`=0), `bus_req` drops after every unit, giving one request per unit. In burst mode, `bus_req` stays high from the first unit until the last, giving one request per run.
- R7: A software channel (`cfg_hw`=0) starts on a `sw_req` pulse. A handshake channel (`cfg_hw`=1) performs a unit only while its `dreq` is high, and samples `dreq` before each unit.
- R8: On a handshake channel, `dreq_clr` pulses high for exactly one cycle after each completed unit in cycle-steal mode, and after the run in burst mode.
- R9: `tc[i]` is high only during the read and write cycles of channel i's final unit.
- R10: `irq[i]` is high once channel i has finished its run or has flagged an error, unless `irq_mask[i]` is set. Clearing the mask exposes a pending interrupt.
- R11: An error response ends the channel's run. It sets `err_sts[i]`, drops `bus_req` on the next cycle, and the channel ignores further requests until it is reloaded.
- R12: The load is rejected, with no bus cycle and `err_sts[i]` set, when any of these holds:
  - the source or destination address is not aligned to the unit size (bit 0 clear for 16 bit, bits 1:0 clear for 32 bit);
  - the size code is 3.
- R13: After reset, `bus_req`, `bus_valid`, `tc`, `dreq_clr`, `irq` and `err_sts` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prio_rr | input | 1 | 1 = round-robin priority, 0 = fixed priority |
| cfg_load | input | 2 | Per-channel load strobe |
| cfg_src | input | 2x32 | Source start address per channel |
| cfg_dst | input | 2x32 | Destination start address per channel |
| cfg_count | input | 2x16 | Unit count per channel, 0 = 65,536 |
| cfg_size | input | 2x2 | Unit size code per channel |
| cfg_burst | input | 2 | 1 = hold the bus for the whole run |
| cfg_src_inc | input | 2 | Source address increment enable |
| cfg_dst_inc | input | 2 | Destination address increment enable |
| cfg_hw | input | 2 | 1 = paced by `dreq`, 0 = software trigger |
| sw_req | input | 2 | Software start pulse per channel |
| dreq | input | 2 | External request line per channel |
| irq_mask | input | 2 | Interrupt mask per channel |
| dreq_clr | output | 2 | Request-clear pulse per channel |
| tc | output | 2 | Final-unit indicator per channel |
| irq | output | 2 | Interrupt per channel |
| err_sts | output | 2 | Sticky error flag per channel |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Bus cycle active |
| bus_we | output | 1 | 1 = write cycle |
| bus_addr | output | 32 | Bus address |
| bus_size | output | 2 | Unit size code of the cycle |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_ready | input | 1 | Cycle completes this clock |
| bus_err | input | 1 | Error response, qualified by ready |

## Verification
The assertions check the following on every cycle:

- A write only ever follows a completed read.
- Bus cycles occur only under request.
- The bus is released or kept after a unit according to the mode.
- An error response always drops the request.
- `tc` is one-hot and confined to bus cycles.
- Every request-clear is a single-cycle pulse.

Other behaviours depend on whole runs and on stimulus ordering, so only the scoreboard scenarios can show them. These are:

- the address and data sequence of a run;
- the unit count, including the 65,536 case;
- fixed versus round-robin interleaving;
- pacing by `dreq`;
- error abort and alignment rejection;
- interrupt masking.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

    localparam int CH_N = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_RD,
        S_WR,
        S_REL,
        S_DONE,
        S_FAIL
    } xfer_st_e;

    // bytes moved per unit for a size code
    function automatic logic [2:0] sz_bytes(input logic [1:0] code);
        case (code)
            2'd0:    sz_bytes = 3'd1;
            2'd1:    sz_bytes = 3'd2;
            default: sz_bytes = 3'd4;
        endcase
    endfunction

    // alignment fault for an address low pair under a size code
    function automatic logic bad_align(input logic [1:0] code, input logic [1:0] lo);
        case (code)
            2'd0:    bad_align = 1'b0;
            2'd1:    bad_align = lo[0];
            2'd2:    bad_align = |lo;
            default: bad_align = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
    import dma2_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [1:0]    size_i,
    input  logic          burst_i,
    input  logic          src_inc_i,
    input  logic          dst_inc_i,
    input  logic          hw_i,
    input  logic          sw_req_i,
    input  logic          dreq_i,
    input  logic          step_i,
    input  logic          fail_i,
    output logic          want_o,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic [1:0]    size_o,
    output logic          burst_o,
    output logic          hw_o,
    output logic          last_o,
    output logic          done_o,
    output logic          err_o
);

    localparam int RW = CW + 1;

    logic [AW-1:0] src_q, dst_q;
    logic [RW-1:0] rem_q;
    logic [1:0]    size_q;
    logic          burst_q, sinc_q, dinc_q, hw_q;
    logic          active_q, pend_q, done_q, err_q;
    logic [AW-1:0] stride;

    assign stride = {{(AW-3){1'b0}}, sz_bytes(size_q)};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= '0;
            dst_q    <= '0;
            rem_q    <= '0;
            size_q   <= '0;
            burst_q  <= 1'b0;
            sinc_q   <= 1'b0;
            dinc_q   <= 1'b0;
            hw_q     <= 1'b0;
            active_q <= 1'b0;
            pend_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else if (load_i && !active_q) begin
            src_q   <= src_i;
            dst_q   <= dst_i;
            size_q  <= size_i;
            burst_q <= burst_i;
            sinc_q  <= src_inc_i;
            dinc_q  <= dst_inc_i;
            hw_q    <= hw_i;
            rem_q   <= (cnt_i == '0) ? (RW'(1) << CW) : RW'(cnt_i);
            pend_q  <= 1'b0;
            done_q  <= 1'b0;
            if (bad_align(size_i, src_i[1:0]) || bad_align(size_i, dst_i[1:0])) begin
                err_q    <= 1'b1;
                active_q <= 1'b0;
            end else begin
                err_q    <= 1'b0;
                active_q <= 1'b1;
            end
        end else begin
            if (sw_req_i && active_q && !hw_q)
                pend_q <= 1'b1;
            if (fail_i) begin
                active_q <= 1'b0;
                err_q    <= 1'b1;
                pend_q   <= 1'b0;
            end else if (step_i) begin
                if (sinc_q) src_q <= src_q + stride;
                if (dinc_q) dst_q <= dst_q + stride;
                rem_q <= rem_q - RW'(1);
                if (rem_q == RW'(1)) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                    pend_q   <= 1'b0;
                end
            end
        end
    end

    assign want_o  = active_q && (hw_q ? dreq_i : pend_q);
    assign src_o   = src_q;
    assign dst_o   = dst_q;
    assign size_o  = size_q;
    assign burst_o = burst_q;
    assign hw_o    = hw_q;
    assign last_o  = (rem_q == RW'(1));
    assign done_o  = done_q;
    assign err_o   = err_q;

endmodule

// File: rtl/dma2_arb.sv
module dma2_arb (
    input  logic [1:0] want_i,
    input  logic       rr_i,
    input  logic       last_i,
    output logic       any_o,
    output logic       pick_o
);

    always_comb begin
        any_o = |want_i;
        unique case (want_i)
            2'b11:   pick_o = rr_i ? ~last_i : 1'b0;
            2'b10:   pick_o = 1'b1;
            default: pick_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma2_engine.sv
module dma2_engine
    import dma2_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prio_rr,
    input  logic [CH_N-1:0]          cfg_load,
    input  logic [CH_N-1:0][AW-1:0]  cfg_src,
    input  logic [CH_N-1:0][AW-1:0]  cfg_dst,
    input  logic [CH_N-1:0][CW-1:0]  cfg_count,
    input  logic [CH_N-1:0][1:0]     cfg_size,
    input  logic [CH_N-1:0]          cfg_burst,
    input  logic [CH_N-1:0]          cfg_src_inc,
    input  logic [CH_N-1:0]          cfg_dst_inc,
    input  logic [CH_N-1:0]          cfg_hw,
    input  logic [CH_N-1:0]          sw_req,
    input  logic [CH_N-1:0]          dreq,
    input  logic [CH_N-1:0]          irq_mask,
    output logic [CH_N-1:0]          dreq_clr,
    output logic [CH_N-1:0]          tc,
    output logic [CH_N-1:0]          irq,
    output logic [CH_N-1:0]          err_sts,
    output logic                     bus_req,
    input  logic                     bus_gnt,
    output logic                     bus_valid,
    output logic                     bus_we,
    output logic [AW-1:0]            bus_addr,
    output logic [1:0]               bus_size,
    output logic [DW-1:0]            bus_wdata,
    input  logic [DW-1:0]            bus_rdata,
    input  logic                     bus_ready,
    input  logic                     bus_err
);

    xfer_st_e state_q, state_d;
    logic     own_q, last_q;
    logic [DW-1:0] buf_q;

    logic [CH_N-1:0]          ch_want, ch_burst, ch_hw, ch_last, ch_done, ch_err;
    logic [CH_N-1:0]          ch_step, ch_fail;
    logic [CH_N-1:0][AW-1:0]  ch_src, ch_dst;
    logic [CH_N-1:0][1:0]     ch_size;
    logic any_req, pick;

    logic [AW-1:0] cur_src, cur_dst;
    logic [1:0]    cur_size;
    logic          cur_burst, cur_hw, cur_last;

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        dma2_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (cfg_load[g]),
            .src_i     (cfg_src[g]),
            .dst_i     (cfg_dst[g]),
            .cnt_i     (cfg_count[g]),
            .size_i    (cfg_size[g]),
            .burst_i   (cfg_burst[g]),
            .src_inc_i (cfg_src_inc[g]),
            .dst_inc_i (cfg_dst_inc[g]),
            .hw_i      (cfg_hw[g]),
            .sw_req_i  (sw_req[g]),
            .dreq_i    (dreq[g]),
            .step_i    (ch_step[g]),
            .fail_i    (ch_fail[g]),
            .want_o    (ch_want[g]),
            .src_o     (ch_src[g]),
            .dst_o     (ch_dst[g]),
            .size_o    (ch_size[g]),
            .burst_o   (ch_burst[g]),
            .hw_o      (ch_hw[g]),
            .last_o    (ch_last[g]),
            .done_o    (ch_done[g]),
            .err_o     (ch_err[g])
        );
    end

    dma2_arb u_arb (
        .want_i (ch_want),
        .rr_i   (prio_rr),
        .last_i (last_q),
        .any_o  (any_req),
        .pick_o (pick)
    );

    assign cur_src   = ch_src[own_q];
    assign cur_dst   = ch_dst[own_q];
    assign cur_size  = ch_size[own_q];
    assign cur_burst = ch_burst[own_q];
    assign cur_hw    = ch_hw[own_q];
    assign cur_last  = ch_last[own_q];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // owner, priority history and data holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q  <= 1'b0;
            last_q <= 1'b1;
            buf_q  <= '0;
        end else begin
            if (state_q == S_IDLE && any_req) begin
                own_q  <= pick;
                last_q <= pick;
            end
            if (state_q == S_RD && bus_ready && !bus_err)
                buf_q <= bus_rdata;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (any_req) state_d = S_REQ;
            S_REQ:  if (bus_gnt) state_d = S_RD;
            S_RD:   if (bus_ready) state_d = bus_err ? S_FAIL : S_WR;
            S_WR: begin
                if (bus_ready) begin
                    if (bus_err)        state_d = S_FAIL;
                    else if (cur_last)  state_d = S_DONE;
                    else if (cur_burst) state_d = S_RD;
                    else                state_d = S_REL;
                end
            end
            S_REL:  state_d = S_IDLE;
            S_DONE: state_d = S_IDLE;
            S_FAIL: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_req   = (state_q == S_REQ) || (state_q == S_RD) || (state_q == S_WR);
        bus_valid = (state_q == S_RD) || (state_q == S_WR);
        bus_we    = (state_q == S_WR);
        bus_addr  = (state_q == S_WR) ? cur_dst : cur_src;
        bus_size  = cur_size;
        bus_wdata = buf_q;
        tc        = '0;
        dreq_clr  = '0;
        ch_step   = '0;
        ch_fail   = '0;
        tc[own_q]       = bus_valid && cur_last;
        dreq_clr[own_q] = ((state_q == S_REL) || (state_q == S_DONE)) && cur_hw;
        ch_step[own_q]  = (state_q == S_WR) && bus_ready && !bus_err;
        ch_fail[own_q]  = bus_valid && bus_ready && bus_err;
        irq       = (ch_done | ch_err) & ~irq_mask;
        err_sts   = ch_err;
    end

endmodule

// File: rtl/dma2_engine_chk.sv
module dma2_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_req,
    input logic       bus_valid,
    input logic       bus_we,
    input logic       bus_ready,
    input logic       bus_err,
    input logic [1:0] tc,
    input logic [1:0] dreq_clr,
    input logic       cur_burst
);

    p_valid_under_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> bus_req);

    p_write_follows_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && !$past(bus_valid && bus_we))
            |-> $past(bus_valid && !bus_we && bus_ready && !bus_err));

    p_burst_keeps_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && bus_ready && !bus_err && (tc == 2'b00) && cur_burst)
            |=> (bus_req && bus_valid && !bus_we));

    p_steal_drops_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && bus_ready && !bus_err && (tc == 2'b00) && !cur_burst)
            |=> !bus_req);

    p_clr_pulse0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dreq_clr[0] |=> !dreq_clr[0]);

    p_clr_pulse1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dreq_clr[1] |=> !dreq_clr[1]);

    p_tc_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tc));

    p_tc_on_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tc != 2'b00) |-> bus_valid);

    p_err_releases_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && bus_err) |=> !bus_req);

endmodule

bind dma2_engine dma2_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_ready (bus_ready),
    .bus_err   (bus_err),
    .tc        (tc),
    .dreq_clr  (dreq_clr),
    .cur_burst (cur_burst)
);

// File: tb/dma2_engine_tb_top.sv
module dma2_engine_tb_top;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prio_rr = 1'b0;
    logic [1:0]        cfg_load = '0;
    logic [1:0][31:0]  cfg_src = '0;
    logic [1:0][31:0]  cfg_dst = '0;
    logic [1:0][15:0]  cfg_count = '0;
    logic [1:0][1:0]   cfg_size = '0;
    logic [1:0] cfg_burst = '0, cfg_src_inc = '0, cfg_dst_inc = '0, cfg_hw = '0;
    logic [1:0] sw_req = '0, dreq = '0, irq_mask = '0;
    logic [1:0] dreq_clr, tc, irq, err_sts;
    logic bus_req, bus_valid, bus_we;
    logic bus_gnt = 1'b0, bus_ready = 1'b0, bus_err = 1'b0;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic [1:0]  bus_size;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma2_engine dut_i (
        .clk(clk), .rst_n(rst_n), .prio_rr(prio_rr), .cfg_load(cfg_load),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count),
        .cfg_size(cfg_size), .cfg_burst(cfg_burst), .cfg_src_inc(cfg_src_inc),
        .cfg_dst_inc(cfg_dst_inc), .cfg_hw(cfg_hw), .sw_req(sw_req),
        .dreq(dreq), .irq_mask(irq_mask), .dreq_clr(dreq_clr), .tc(tc),
        .irq(irq), .err_sts(err_sts), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .bus_err(bus_err)
    );

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        logic [1:0]  size;
        logic [1:0]  tcv;
    } wr_item_t;

    wr_item_t exp_q[$];
    int total = 0;
    int bad = 0;
    int req_rises = 0;
    int wr_cnt = 0;
    int clr_cnt[2] = '{0, 0};
    logic slow = 1'b0;
    logic waited = 1'b0;
    logic err_on = 1'b0;
    logic [31:0] err_addr = '0;
    logic prev_req = 1'b0;

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz, input logic [1:0] t);
        wr_item_t it;
        it.addr = a; it.data = d; it.size = sz; it.tcv = t;
        exp_q.push_back(it);
    endtask

    // bus model and scoreboard monitor
    always @(negedge clk) begin
        bus_gnt = bus_req;
        if (bus_req && !prev_req) req_rises++;
        prev_req = bus_req;
        for (int c = 0; c < 2; c++)
            if (dreq_clr[c]) begin
                dreq[c] = 1'b0;
                clr_cnt[c]++;
            end
        if (bus_valid) begin
            if (slow && !waited) begin
                bus_ready = 1'b0;
                waited = 1'b1;
            end else begin
                bus_ready = 1'b1;
                waited = 1'b0;
            end
            bus_err = bus_ready && err_on && !bus_we && (bus_addr == err_addr);
            bus_rdata = mem_val(bus_addr);
            if (bus_ready && bus_we && !bus_err) begin
                wr_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected write", bus_addr, 32'h0);
                end else begin
                    wr_item_t e;
                    e = exp_q.pop_front();
                    chk(bus_addr == e.addr, "R2 write address", bus_addr, e.addr);
                    chk(bus_wdata == e.data, "R1 write data", bus_wdata, e.data);
                    chk(bus_size == e.size, "R1 size code", {30'd0, bus_size}, {30'd0, e.size});
                    chk(tc == e.tcv, "R9 final-unit flag", {30'd0, tc}, {30'd0, e.tcv});
                end
            end
        end else begin
            bus_ready = 1'b0;
            bus_err = 1'b0;
        end
    end

    task automatic load_ch(input int ch, input logic [31:0] s, input logic [31:0] d,
                           input logic [15:0] n, input logic [1:0] sz, input logic b,
                           input logic si, input logic di, input logic hw);
        @(negedge clk);
        cfg_src[ch] = s; cfg_dst[ch] = d; cfg_count[ch] = n; cfg_size[ch] = sz;
        cfg_burst[ch] = b; cfg_src_inc[ch] = si; cfg_dst_inc[ch] = di; cfg_hw[ch] = hw;
        cfg_load[ch] = 1'b1;
        @(negedge clk);
        cfg_load[ch] = 1'b0;
    endtask

    task automatic kick(input logic [1:0] m);
        @(negedge clk);
        sw_req = m;
        @(negedge clk);
        sw_req = '0;
    endtask

    task automatic wait_quiet();
        @(negedge clk);
        while (exp_q.size() != 0 || bus_req) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int r0, c0, w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(!bus_req && !bus_valid, "R13 bus idle", {31'd0, bus_req}, 32'd0);
        chk(tc == 0 && dreq_clr == 0, "R13 tc/clr low", {28'd0, tc, dreq_clr}, 32'd0);
        chk(irq == 0 && err_sts == 0, "R13 irq/err low", {28'd0, irq, err_sts}, 32'd0);

        // cycle-steal, 32-bit, both increment, wait states
        slow = 1'b1;
        load_ch(0, 32'h100, 32'h200, 16'd3, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
        push(32'h200, mem_val(32'h100), 2'd2, 2'b00);
        push(32'h204, mem_val(32'h104), 2'd2, 2'b00);
        push(32'h208, mem_val(32'h108), 2'd2, 2'b01);
        r0 = req_rises;
        kick(2'b01);
        wait_quiet();
        chk(req_rises - r0 == 3, "R6 steal one request per unit", req_rises - r0, 3);
        chk(irq[0] == 1'b1, "R10 done interrupt ch0", {31'd0, irq[0]}, 1);

        // burst, 16-bit, source fixed
        slow = 1'b0;
        load_ch(1, 32'h302, 32'h400, 16'd4, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++)
            push(32'h400 + 2 * k, mem_val(32'h302), 2'd1, (k == 3) ? 2'b10 : 2'b00);
        r0 = req_rises;
        kick(2'b10);
        wait_quiet();
        chk(req_rises - r0 == 1, "R6 burst single request", req_rises - r0, 1);
        chk(irq[1] == 1'b1, "R10 done interrupt ch1", {31'd0, irq[1]}, 1);

        // R4 fixed priority
        prio_rr = 1'b0;
        load_ch(0, 32'h1000, 32'h2000, 16'd2, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
        load_ch(1, 32'h3000, 32'h4000, 16'd2, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
        push(32'h2000, mem_val(32'h1000), 2'd2, 2'b00);
        push(32'h2004, mem_val(32'h1004), 2'd2, 2'b01);
        push(32'h4000, mem_val(32'h3000), 2'd2, 2'b00);
        push(32'h4004, mem_val(32'h3004), 2'd2, 2'b10);
        kick(2'b11);
        wait_quiet();
        chk(exp_q.size() == 0, "R4 fixed order drained", exp_q.size(), 0);

        // R5 round robin
        prio_rr = 1'b1;
        load_ch(0, 32'h5000, 32'h6000, 16'd2, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
        load_ch(1, 32'h7000, 32'h8000, 16'd2, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
        push(32'h6000, mem_val(32'h5000), 2'd2, 2'b00);
        push(32'h8000, mem_val(32'h7000), 2'd2, 2'b00);
        push(32'h6004, mem_val(32'h5004), 2'd2, 2'b01);
        push(32'h8004, mem_val(32'h7004), 2'd2, 2'b10);
        kick(2'b11);
        wait_quiet();
        chk(exp_q.size() == 0, "R5 alternating order drained", exp_q.size(), 0);
        prio_rr = 1'b0;

        // R7 / R8 handshake channel, 8-bit
        load_ch(0, 32'h501, 32'h601, 16'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1);
        push(32'h601, mem_val(32'h501), 2'd0, 2'b00);
        push(32'h602, mem_val(32'h502), 2'd0, 2'b01);
        c0 = clr_cnt[0];
        @(negedge clk);
        dreq[0] = 1'b1;
        while (clr_cnt[0] == c0) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(exp_q.size() == 1, "R7 no unit without dreq", exp_q.size(), 1);
        dreq[0] = 1'b1;
        wait_quiet();
        chk(clr_cnt[0] - c0 == 2, "R8 clear pulse per unit", clr_cnt[0] - c0, 2);

        // R12 misaligned load
        r0 = req_rises;
        load_ch(1, 32'h702, 32'h800, 16'd2, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        chk(err_sts[1] == 1'b1, "R12 misalign flagged", {31'd0, err_sts[1]}, 1);
        chk(irq[1] == 1'b1, "R12 misalign interrupt", {31'd0, irq[1]}, 1);
        kick(2'b10);
        repeat (6) @(negedge clk);
        chk(req_rises == r0, "R12 no bus cycle", req_rises - r0, 0);

        // R11 bus error on the second read
        err_on = 1'b1;
        err_addr = 32'h904;
        load_ch(0, 32'h900, 32'hA00, 16'd3, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
        push(32'hA00, mem_val(32'h900), 2'd2, 2'b00);
        kick(2'b01);
        while (!err_sts[0]) @(negedge clk);
        repeat (4) @(negedge clk);
        err_on = 1'b0;
        chk(err_sts[0] == 1'b1, "R11 error flag", {31'd0, err_sts[0]}, 1);
        chk(irq[0] == 1'b1, "R11 error interrupt", {31'd0, irq[0]}, 1);
        chk(exp_q.size() == 0, "R11 no write after error", exp_q.size(), 0);
        r0 = req_rises;
        kick(2'b01);
        repeat (6) @(negedge clk);
        chk(req_rises == r0, "R11 stopped channel ignores request", req_rises - r0, 0);

        // R10 masking
        irq_mask[1] = 1'b1;
        load_ch(1, 32'hB00, 32'hC00, 16'd1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
        push(32'hC00, mem_val(32'hB00), 2'd2, 2'b10);
        kick(2'b10);
        wait_quiet();
        chk(irq[1] == 1'b0, "R10 masked interrupt", {31'd0, irq[1]}, 0);
        irq_mask[1] = 1'b0;
        @(negedge clk);
        chk(irq[1] == 1'b1, "R10 unmasked interrupt", {31'd0, irq[1]}, 1);

        // R3 count zero means 65536 units
        load_ch(0, 32'hD00, 32'hE00, 16'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 65536; k++)
            push(32'hE00, mem_val(32'hD00), 2'd0, (k == 65535) ? 2'b01 : 2'b00);
        w0 = wr_cnt;
        kick(2'b01);
        wait_quiet();
        chk(wr_cnt - w0 == 65536, "R3 full-range count", wr_cnt - w0, 65536);
        chk(irq[0] == 1'b1, "R3 run completes", {31'd0, irq[0]}, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule